// File: doc/BRIEF.md
# Trip Threshold Command Decoder

This block sits behind a byte-level two-wire serial slave engine and picks out the write commands that program or clear one of three supply-supervisor trip thresholds. The serial engine reports three things: a start condition, a stop condition, and each received byte together with its value. The block answers each byte it accepts with an acknowledge. A separate input reports that the high programming voltage is present on the dedicated pin.

A command counts only when it has the following shape:
- the programming voltage was already present when the start condition arrived;
- the transfer then carries the device byte, one threshold byte address and one zero data byte;
- a stop condition closes it.

The stop turns a good command into one active request line, either a program request or a clear request for one channel. That line stays high until the programming voltage goes away. The request then drops, and a one-cycle completion pulse is given. While a request is held, new transfers are ignored. The analog trimming and the calibration loop run by software are handled elsewhere.

Top module: `trip_cmd_decoder`

## Requirements
- R1: The first byte after an armed start is accepted (ack one cycle after the byte strobe) only when it equals the device byte A0h. Any other value gets no ack and abandons the transfer.
- R2: The address bytes 01h, 09h and 0Dh select a program command for channel 0, 1 and 2. After the zero data byte and the stop, this raises `prog_req` bit 0, 1 or 2.
- R3: The address bytes 03h, 0Bh and 0Fh select a clear command for channel 0, 1 and 2. After the zero data byte and the stop, this raises `rst_req` bit 0, 1 or 2. Bit 1 of the address selects clear, and bits 3:2 select the channel: 00 for channel 0, 10 for channel 1, 11 for channel 2.
- R4: If `hv_ok` is low in the cycle of the start condition, the whole transfer is ignored: it gets no ack and raises no request, even if `hv_ok` rises afterwards.
- R5: A request line rises in the cycle after the stop that closes a valid command, and never at any other time.
- R6: A request line stays high while `hv_ok` stays high. In the first cycle after `hv_ok` is sampled low, the request line is cleared and `done` is high for exactly one cycle.
- R7: Any of the following abandons the command, raises no request and gets no ack for the offending byte:
  - a data byte other than 00h;
  - a second data byte;
  - an address byte outside the six codes;
  - a repeated start before the stop.
- R8: At most one bit across `prog_req` and `rst_req` is ever high. A start that arrives while a request is held is ignored, together with the rest of its transfer.
- R9: After reset, `ack`, `prog_req`, `rst_req` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start (or repeated start) seen, one-cycle pulse |
| bus_stop | input | 1 | Stop seen, one-cycle pulse |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Value of the received byte |
| hv_ok | input | 1 | High programming voltage present |
| ack | output | 1 | Acknowledge for the byte strobed in the previous cycle |
| prog_req | output | 3 | One-hot program request per channel |
| rst_req | output | 3 | One-hot clear request per channel |
| done | output | 1 | One-cycle pulse when a request ends |

## Verification
The bench builds the block with its default parameters: three channels and device byte A0h. These defaults reach all six address codes. They also reach the bit-field channel decode, including the unused code 05h. The bench drives good commands and commands broken at each byte position. It also checks the ordering between `hv_ok` and the start, and it sends a whole transfer while a request is held to show that the busy lockout works.

// File: rtl/trip_cmd_pkg.sv
package trip_cmd_pkg;

  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for an armed start
    ST_DEV,    // expecting device byte
    ST_ADDR,   // expecting threshold address
    ST_DATA,   // expecting zero data byte
    ST_STOP,   // command complete, waiting for stop
    ST_DROP    // transfer abandoned until next stop/start
  } parse_st_e;

  typedef struct packed {
    logic       valid;
    logic       is_clr;
    logic [1:0] ch;
  } cmd_t;

  // Address layout: bit0 must be 1, bit1 selects clear, bits[3:2] pick channel.
  function automatic cmd_t decode_addr(input logic [BYTE_W-1:0] a);
    cmd_t c;
    c = '0;
    if (a[BYTE_W-1:4] == '0 && a[0]) begin
      c.is_clr = a[1];
      unique case (a[3:2])
        2'b00:   begin c.valid = 1'b1; c.ch = 2'd0; end
        2'b10:   begin c.valid = 1'b1; c.ch = 2'd1; end
        2'b11:   begin c.valid = 1'b1; c.ch = 2'd2; end
        default: begin c.valid = 1'b0; c.ch = 2'd0; end
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/trip_cmd_parser.sv
module trip_cmd_parser
  import trip_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_BYTE = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              hv_ok,
  input  logic              busy,
  output logic              ack,
  output logic              fire,
  output cmd_t              fire_cmd
);

  parse_st_e st_q, st_d;
  cmd_t      cmd_q, cmd_d;
  logic      ack_q, ack_d;
  cmd_t      dec;

  assign dec = decode_addr(byte_data);

  always_comb begin
    st_d  = st_q;
    cmd_d = cmd_q;
    ack_d = 1'b0;
    fire  = 1'b0;
    if (bus_start) begin
      if (busy)               st_d = ST_IDLE;
      else if (st_q != ST_IDLE && st_q != ST_DROP) st_d = ST_DROP; // repeated start
      else if (hv_ok)         st_d = ST_DEV;
      else                    st_d = ST_DROP;
    end else if (bus_stop) begin
      if (st_q == ST_STOP) fire = 1'b1;
      st_d = ST_IDLE;
    end else if (byte_vld) begin
      unique case (st_q)
        ST_DEV: begin
          if (byte_data == DEV_BYTE) begin ack_d = 1'b1; st_d = ST_ADDR; end
          else st_d = ST_DROP;
        end
        ST_ADDR: begin
          if (dec.valid) begin ack_d = 1'b1; cmd_d = dec; st_d = ST_DATA; end
          else st_d = ST_DROP;
        end
        ST_DATA: begin
          if (byte_data == '0) begin ack_d = 1'b1; st_d = ST_STOP; end
          else st_d = ST_DROP;
        end
        ST_STOP: st_d = ST_DROP;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= '0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
      if (byte_vld) cmd_q <= cmd_d;
    end
  end

  assign ack      = ack_q;
  assign fire_cmd = cmd_q;

  // R1
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(byte_vld));

  // R7
  no_fire_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_start) |-> st_q != ST_STOP);

endmodule

// File: rtl/trip_req_ctrl.sv
module trip_req_ctrl
  import trip_cmd_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  cmd_t          fire_cmd,
  input  logic          hv_ok,
  output logic          busy,
  output logic [CH-1:0] prog_req,
  output logic [CH-1:0] rst_req,
  output logic          done
);

  logic [CH-1:0] prog_q, prog_d, clr_q, clr_d;
  logic          done_q, done_d;
  logic [CH-1:0] sel;

  assign sel  = CH'(1) << fire_cmd.ch;
  assign busy = |{prog_q, clr_q};

  always_comb begin
    prog_d = prog_q;
    clr_d  = clr_q;
    done_d = 1'b0;
    if (busy) begin
      if (!hv_ok) begin
        prog_d = '0;
        clr_d  = '0;
        done_d = 1'b1;
      end
    end else if (fire) begin
      if (fire_cmd.is_clr) clr_d  = sel;
      else                 prog_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      clr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      prog_q <= prog_d;
      clr_q  <= clr_d;
      done_q <= done_d;
    end
  end

  assign prog_req = prog_q;
  assign rst_req  = clr_q;
  assign done     = done_q;

  // R8
  onehot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_q, clr_q}));

  // R5
  req_rise_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fire));

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !$past(hv_ok) && !busy));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(hv_ok)) |-> $stable({prog_q, clr_q}));

endmodule

// File: rtl/trip_cmd_decoder.sv
module trip_cmd_decoder
  import trip_cmd_pkg::*;
#(
  parameter logic [7:0] DEV_BYTE = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       hv_ok,
  output logic       ack,
  output logic [2:0] prog_req,
  output logic [2:0] rst_req,
  output logic       done
);

  logic busy;
  logic fire;
  cmd_t fire_cmd;

  trip_cmd_parser #(.DEV_BYTE(DEV_BYTE)) u_parser (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_vld(byte_vld), .byte_data(byte_data), .hv_ok(hv_ok), .busy(busy),
    .ack(ack), .fire(fire), .fire_cmd(fire_cmd)
  );

  trip_req_ctrl #(.CH(NUM_CH)) u_req (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_cmd(fire_cmd), .hv_ok(hv_ok),
    .busy(busy), .prog_req(prog_req), .rst_req(rst_req), .done(done)
  );

endmodule

// File: tb/trip_cmd_decoder_tb.sv
module trip_cmd_decoder_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_start, bus_stop, byte_vld, hv_ok;
  logic [7:0] byte_data;
  logic ack, done;
  logic [2:0] prog_req, rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trip_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_vld(byte_vld), .byte_data(byte_data), .hv_ok(hv_ok),
    .ack(ack), .prog_req(prog_req), .rst_req(rst_req), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  // returns at the negedge after the strobe; ack is visible then
  task automatic do_byte(input logic [7:0] b, output logic a);
    @(negedge clk); byte_vld = 1'b1; byte_data = b;
    @(negedge clk); byte_vld = 1'b0; byte_data = 8'h00;
    a = ack;
  endtask

  task automatic end_hv(input string tag);
    @(negedge clk); hv_ok = 1'b0;
    @(negedge clk);
    chk({tag, " done pulse"}, {31'd0, done}, 32'd1);
    chk({tag, " req cleared"}, {26'd0, prog_req, rst_req}, 32'd0);
    @(negedge clk);
    chk({tag, " done single"}, {31'd0, done}, 32'd0);
  endtask

  task automatic full_cmd(input logic [7:0] addr, input logic [2:0] exp_p,
                          input logic [2:0] exp_r, input string tag);
    logic a;
    @(negedge clk); hv_ok = 1'b1;
    do_start();
    do_byte(8'hA0, a); chk({tag, " R1 dev ack"}, {31'd0, a}, 32'd1);
    do_byte(addr, a);  chk({tag, " addr ack"}, {31'd0, a}, 32'd1);
    do_byte(8'h00, a); chk({tag, " data ack"}, {31'd0, a}, 32'd1);
    chk({tag, " R5 no req before stop"}, {26'd0, prog_req, rst_req}, 32'd0);
    do_stop();
    chk({tag, " req"}, {26'd0, prog_req, rst_req}, {26'd0, exp_p, exp_r});
    repeat (3) @(negedge clk);
    chk({tag, " R6 held"}, {26'd0, prog_req, rst_req}, {26'd0, exp_p, exp_r});
    end_hv({tag, " R6"});
  endtask

  task automatic t_reset();
    chk("R9 reset outputs", {24'd0, ack, prog_req, rst_req, done}, 32'd0);
  endtask

  task automatic t_program();
    full_cmd(8'h01, 3'b001, 3'b000, "R2 ch0");
    full_cmd(8'h09, 3'b010, 3'b000, "R2 ch1");
    full_cmd(8'h0D, 3'b100, 3'b000, "R2 ch2");
  endtask

  task automatic t_clear();
    full_cmd(8'h03, 3'b000, 3'b001, "R3 ch0");
    full_cmd(8'h0B, 3'b000, 3'b010, "R3 ch1");
    full_cmd(8'h0F, 3'b000, 3'b100, "R3 ch2");
  endtask

  task automatic t_no_hv();
    logic a;
    @(negedge clk); hv_ok = 1'b0;
    do_start();
    @(negedge clk); hv_ok = 1'b1;
    do_byte(8'hA0, a); chk("R4 no ack unarmed", {31'd0, a}, 32'd0);
    do_byte(8'h01, a);
    do_byte(8'h00, a);
    do_stop();
    @(negedge clk);
    chk("R4 no req unarmed", {26'd0, prog_req, rst_req}, 32'd0);
  endtask

  task automatic t_bad_dev();
    logic a;
    @(negedge clk); hv_ok = 1'b1;
    do_start();
    do_byte(8'hA2, a); chk("R1 wrong dev nack", {31'd0, a}, 32'd0);
    do_byte(8'h01, a); chk("R1 addr after wrong dev nack", {31'd0, a}, 32'd0);
    do_byte(8'h00, a);
    do_stop();
    chk("R1 wrong dev no req", {26'd0, prog_req, rst_req}, 32'd0);
  endtask

  task automatic t_bad_data();
    logic a;
    do_start();
    do_byte(8'hA0, a);
    do_byte(8'h09, a);
    do_byte(8'h01, a); chk("R7 nonzero data nack", {31'd0, a}, 32'd0);
    do_stop();
    chk("R7 nonzero data no req", {26'd0, prog_req, rst_req}, 32'd0);
  endtask

  task automatic t_extra_data();
    logic a;
    do_start();
    do_byte(8'hA0, a);
    do_byte(8'h0D, a);
    do_byte(8'h00, a);
    do_byte(8'h00, a); chk("R7 second data nack", {31'd0, a}, 32'd0);
    do_stop();
    chk("R7 second data no req", {26'd0, prog_req, rst_req}, 32'd0);
  endtask

  task automatic t_bad_addr();
    logic a;
    do_start();
    do_byte(8'hA0, a);
    do_byte(8'h05, a); chk("R7 unused addr nack", {31'd0, a}, 32'd0);
    do_byte(8'h00, a);
    do_stop();
    chk("R7 unused addr no req", {26'd0, prog_req, rst_req}, 32'd0);
  endtask

  task automatic t_restart();
    logic a;
    do_start();
    do_byte(8'hA0, a);
    do_byte(8'h03, a);
    do_byte(8'h00, a);
    do_start();
    do_stop();
    chk("R7 repeated start no req", {26'd0, prog_req, rst_req}, 32'd0);
  endtask

  task automatic t_busy();
    logic a;
    @(negedge clk); hv_ok = 1'b1;
    do_start();
    do_byte(8'hA0, a); do_byte(8'h01, a); do_byte(8'h00, a);
    do_stop();
    chk("R8 first req", {26'd0, prog_req, rst_req}, {26'd0, 3'b001, 3'b000});
    do_start();
    do_byte(8'hA0, a); chk("R8 busy nack", {31'd0, a}, 32'd0);
    do_byte(8'h0B, a);
    do_byte(8'h00, a);
    do_stop();
    @(negedge clk);
    chk("R8 busy ignored", {26'd0, prog_req, rst_req}, {26'd0, 3'b001, 3'b000});
    end_hv("R8 busy end");
  endtask

  initial begin
    rst_n = 1'b0; bus_start = 1'b0; bus_stop = 1'b0; byte_vld = 1'b0;
    byte_data = 8'h00; hv_ok = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_clear();
    t_no_hv();
    t_bad_dev();
    t_bad_data();
    t_extra_data();
    t_bad_addr();
    t_restart();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule